// File: doc/BRIEF.md
# Protected Two-Wire Register Slave

This block is a serial slave on a two-wire bus (clock line plus open-drain data line). It serves a 9-bit address space up to 10Fh. The space holds a look-up table and control bytes, and the block reaches them through a simple memory-side port. The block samples both bus lines with the system clock and finds START and STOP conditions. It matches a device byte whose middle three bits come from strap pins. It then carries out byte writes, page writes, random reads and current-address reads.

Every data write is gated. A write-enable bit lives inside the block and the master reaches it at its own address. An external protect pin also blocks writes. A data byte that is refused is not acknowledged. Writes that reach the memory start an internal nonvolatile cycle at the following STOP. While that cycle runs, the slave does not acknowledge its device byte, so the master can poll for completion.

The memory port carries no back-pressure. The memory must accept a write in any cycle that `mem_we` is high, and it returns `mem_rdata` combinationally for `mem_raddr`. The bus side has no flow control beyond the ACK bit.

Top module: `tw_prot_slave`

## Requirements
- R1: START (data falls while clock is high) always restarts byte reception. STOP (data rises while clock is high) returns the slave to idle and releases the data line. After a device byte that is not acknowledged, the slave ignores the bus until the next START. After reset, `sda_oe` and `mem_we` are low.
- R2: The device byte is acknowledged only when its bits 7:5 equal 3'b101 and its bits 4:2 equal `strap[2:0]`. Bit 0 is the read flag (1 = read).
- R3: In a write header, device-byte bit 1 becomes address bit 8. The next byte (always acknowledged) gives address bits 7:0. Bit 1 of a read header is ignored.
- R4: The write-enable bit is bit 0 of the byte at address 08Ch, and reset clears it. A write there is accepted and acknowledged whenever `wp` is low, whatever the bit's current value. Reading 08Ch returns {7'b0, bit}. Address 08Ch never reaches the memory port.
- R5: While `wp` is high, every data byte is refused without ACK: no `mem_we`, and the write-enable bit keeps its value.
- R6: While the write-enable bit is 0, a data byte to any address other than 08Ch is refused without ACK and produces no `mem_we`.
- R7: An accepted data byte produces exactly one cycle of `mem_we`, with `mem_waddr` set to the current address and `mem_wdata` to the byte, and it is acknowledged.
- R8: During a write, the address advances in its low 4 bits only, wrapping inside its aligned 16-byte page.
- R9: During a read, the address advances linearly and wraps from 10Fh to 000h. A current-address read resumes where the previous transfer left the address.
- R10: A random read (START, write header, address byte, repeated START, read header) acknowledges all three header bytes and returns data from the given address.
- R11: The slave keeps sending bytes while the master acknowledges each one. After a master NACK, the slave releases the data line and stays silent.
- R12: Writes to addresses above 10Fh are refused without ACK. Reads there return FFh.
- R13: A STOP that ends a transfer with at least one `mem_we` starts a busy window of `NV_CYCLES` clocks. During that window device bytes get no ACK. A transfer that only writes 08Ch starts no window.
- R14: The slave changes `sda_oe` only while `scl_in` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line |
| sda_in | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls the data line low |
| strap | input | 3 | Strap pins matched against device-byte bits 4:2 |
| wp | input | 1 | Write protect, active high |
| mem_we | output | 1 | One-cycle memory write strobe |
| mem_waddr | output | 9 | Memory write address |
| mem_wdata | output | 8 | Memory write data |
| mem_raddr | output | 9 | Memory read address (current pointer) |
| mem_rdata | input | 8 | Memory read data, combinational |

## Verification
The bench writes a page-crossing burst that starts at 01Eh and then reads the same range back. A design that wrapped linearly on writes would corrupt 020h, and one that wrapped within the page on reads would return 010h after 01Fh. It tries writes with the enable bit clear, with the protect pin high, and to address 120h. A design that leaked any of them would show a changed memory image or an ACK where none is due. It polls straight after a table write and after a latch-only write, which catches a busy window that is missing or started without cause. It reads across 10Fh and to 08Ch, where a design without the wrap or the latch readback returns the wrong byte.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int ADDR_W = 9;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_RDAT,
    ST_RD_ACK
  } tw_state_e;
endpackage

// File: rtl/tw_cond_detect.sv
module tw_cond_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_pipe;
  logic [SYNC_STAGES-1:0] sda_pipe;
  logic scl_s, scl_d, sda_d;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe[0] <= 1'b1;
          sda_pipe[0] <= 1'b1;
        end else begin
          scl_pipe[0] <= scl_in;
          sda_pipe[0] <= sda_in;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe[i] <= 1'b1;
          sda_pipe[i] <= 1'b1;
        end else begin
          scl_pipe[i] <= scl_pipe[i-1];
          sda_pipe[i] <= sda_pipe[i-1];
        end
      end
    end
  end

  assign scl_s = scl_pipe[SYNC_STAGES-1];
  assign sda_s = sda_pipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/tw_addr_ptr.sv
module tw_addr_ptr
  import tw_pkg::*;
#(
  parameter int PAGE_BITS = 4,
  parameter logic [ADDR_W-1:0] MAX_ADDR = 9'h10F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              inc_page,
  input  logic              inc_lin,
  output logic [ADDR_W-1:0] ptr
);
  logic [ADDR_W-1:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (load) begin
      ptr_q <= load_val;
    end else if (inc_page) begin
      ptr_q <= {ptr_q[ADDR_W-1:PAGE_BITS], ptr_q[PAGE_BITS-1:0] + PAGE_BITS'(1)};
    end else if (inc_lin) begin
      ptr_q <= (ptr_q == MAX_ADDR) ? '0 : ptr_q + ADDR_W'(1);
    end
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/tw_guard.sv
module tw_guard #(
  parameter int NV_CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic busy
);
  localparam int CW = $clog2(NV_CYCLES + 1);
  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (arm) begin
      remain <= CW'(NV_CYCLES);
    end else if (remain != '0) begin
      remain <= remain - CW'(1);
    end
  end

  assign busy = (remain != '0);
endmodule

// File: rtl/tw_prot_slave.sv
module tw_prot_slave
  import tw_pkg::*;
#(
  parameter logic [2:0]        DEV_CODE    = 3'b101,
  parameter int                PAGE_BITS   = 4,
  parameter logic [ADDR_W-1:0] MAX_ADDR    = 9'h10F,
  parameter logic [ADDR_W-1:0] LATCH_ADDR  = 9'h08C,
  parameter int                NV_CYCLES   = 5000,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  input  logic [2:0]        strap,
  input  logic              wp,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic [ADDR_W-1:0] mem_raddr,
  input  logic [BYTE_W-1:0] mem_rdata
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic busy;
  logic [ADDR_W-1:0] ptr;

  tw_state_e         state;
  logic [3:0]        cnt;
  logic [BYTE_W-1:0] shreg, obyte;
  logic              sda_oe_q, rd_mode, hi_q, m_ack, wel_q, nv_pend;
  logic              mem_we_q;
  logic [ADDR_W-1:0] waddr_q;
  logic [BYTE_W-1:0] wdata_q;

  logic              byte_done, no_evt, dev_match, at_latch, wr_ok;
  logic [BYTE_W-1:0] rd_byte;

  tw_cond_detect #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  tw_guard #(.NV_CYCLES(NV_CYCLES)) u_guard (
    .clk  (clk),
    .rst_n(rst_n),
    .arm  (stop_det & nv_pend),
    .busy (busy)
  );

  assign no_evt    = ~start_det & ~stop_det;
  assign byte_done = scl_fall && (cnt == 4'd8);

  tw_addr_ptr #(.PAGE_BITS(PAGE_BITS), .MAX_ADDR(MAX_ADDR)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (no_evt && state == ST_ADDR && byte_done),
    .load_val({hi_q, shreg}),
    .inc_page(no_evt && state == ST_WDAT && byte_done),
    .inc_lin (no_evt && state == ST_RDAT && byte_done),
    .ptr     (ptr)
  );

  always_comb begin
    dev_match = (shreg[7:5] == DEV_CODE) && (shreg[4:2] == strap);
    at_latch  = (ptr == LATCH_ADDR);
    wr_ok     = !wp && (at_latch || (wel_q && ptr <= MAX_ADDR));
    if (at_latch)             rd_byte = {7'b0, wel_q};
    else if (ptr > MAX_ADDR)  rd_byte = 8'hFF;
    else                      rd_byte = mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      obyte    <= '0;
      sda_oe_q <= 1'b0;
      rd_mode  <= 1'b0;
      hi_q     <= 1'b0;
      m_ack    <= 1'b0;
      wel_q    <= 1'b0;
      nv_pend  <= 1'b0;
      mem_we_q <= 1'b0;
      waddr_q  <= '0;
      wdata_q  <= '0;
    end else begin
      mem_we_q <= 1'b0;
      if (start_det) begin
        state    <= ST_DEV;
        cnt      <= '0;
        sda_oe_q <= 1'b0;
      end else if (stop_det) begin
        state    <= ST_IDLE;
        sda_oe_q <= 1'b0;
        nv_pend  <= 1'b0;
      end else begin
        case (state)
          ST_DEV: begin
            if (scl_rise && cnt != 4'd8) begin
              shreg <= {shreg[6:0], sda_s};
              cnt   <= cnt + 4'd1;
            end else if (byte_done) begin
              cnt <= '0;
              if (dev_match && !busy) begin
                sda_oe_q <= 1'b1;
                rd_mode  <= shreg[0];
                if (!shreg[0]) hi_q <= shreg[1];
                state    <= ST_DEV_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_DEV_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rd_mode) begin
                state    <= ST_RDAT;
                obyte    <= rd_byte;
                sda_oe_q <= ~rd_byte[7];
              end else begin
                state    <= ST_ADDR;
                sda_oe_q <= 1'b0;
              end
            end
          end
          ST_ADDR: begin
            if (scl_rise && cnt != 4'd8) begin
              shreg <= {shreg[6:0], sda_s};
              cnt   <= cnt + 4'd1;
            end else if (byte_done) begin
              cnt      <= '0;
              sda_oe_q <= 1'b1;
              state    <= ST_ADDR_ACK;
            end
          end
          ST_ADDR_ACK, ST_WDAT_ACK: begin
            if (scl_fall) begin
              cnt      <= '0;
              sda_oe_q <= 1'b0;
              state    <= ST_WDAT;
            end
          end
          ST_WDAT: begin
            if (scl_rise && cnt != 4'd8) begin
              shreg <= {shreg[6:0], sda_s};
              cnt   <= cnt + 4'd1;
            end else if (byte_done) begin
              cnt      <= '0;
              sda_oe_q <= wr_ok;
              state    <= ST_WDAT_ACK;
              if (at_latch) begin
                if (!wp) wel_q <= shreg[0];
              end else if (wr_ok) begin
                mem_we_q <= 1'b1;
                waddr_q  <= ptr;
                wdata_q  <= shreg;
                nv_pend  <= 1'b1;
              end
            end
          end
          ST_RDAT: begin
            if (scl_rise && cnt != 4'd8) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe_q <= 1'b0;
                state    <= ST_RD_ACK;
              end else if (cnt != 4'd0) begin
                sda_oe_q <= ~obyte[3'd7 - cnt[2:0]];
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              m_ack <= ~sda_s;
            end else if (scl_fall) begin
              cnt <= '0;
              if (m_ack) begin
                state    <= ST_RDAT;
                obyte    <= rd_byte;
                sda_oe_q <= ~rd_byte[7];
              end else begin
                state    <= ST_IDLE;
                sda_oe_q <= 1'b0;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign sda_oe    = sda_oe_q;
  assign mem_we    = mem_we_q;
  assign mem_waddr = waddr_q;
  assign mem_wdata = wdata_q;
  assign mem_raddr = ptr;
endmodule

// File: rtl/tw_prot_slave_chk.sv
module tw_prot_slave_chk
  import tw_pkg::*;
#(
  parameter logic [ADDR_W-1:0] MAX_ADDR   = 9'h10F,
  parameter logic [ADDR_W-1:0] LATCH_ADDR = 9'h08C
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_in,
  input logic              sda_oe,
  input logic              wp,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_waddr,
  input logic              wel_q
);
  AST_SDA_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_in); // R14

  AST_WP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !$past(wp)); // R5

  AST_WP_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wel_q) |-> !$past(wp)); // R5

  AST_WE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(wel_q)); // R6

  AST_WE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_waddr <= MAX_ADDR && mem_waddr != LATCH_ADDR)); // R12

  AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we); // R7
endmodule

bind tw_prot_slave tw_prot_slave_chk #(
  .MAX_ADDR  (MAX_ADDR),
  .LATCH_ADDR(LATCH_ADDR)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_in   (scl_in),
  .sda_oe   (sda_oe),
  .wp       (wp),
  .mem_we   (mem_we),
  .mem_waddr(mem_waddr),
  .wel_q    (wel_q)
);

// File: tb/test_tw_prot_slave.sv
module test_tw_prot_slave;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 300;
  localparam int Q = 8;
  localparam logic [8:0] MAXA  = 9'h10F;
  localparam logic [8:0] LATCH = 9'h08C;
  localparam logic [2:0] CODE  = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [2:0] strap = 3'b010;
  logic wp = 1'b0;
  logic sda_oe, mem_we;
  logic [8:0] mem_waddr, mem_raddr;
  logic [7:0] mem_wdata, mem_rdata;
  wire sda_line = m_sda & ~sda_oe;

  logic [7:0] dut_mem [0:511];
  logic [7:0] exp_mem [0:511];
  int total = 0, bad = 0;
  bit m_wel = 1'b0;
  bit m_busy = 1'b0;
  logic [8:0] m_ptr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (mem_we) dut_mem[mem_waddr] <= mem_wdata;
  assign mem_rdata = dut_mem[mem_raddr];

  tw_prot_slave #(.NV_CYCLES(NV)) i_tw_prot_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line), .sda_oe(sda_oe),
    .strap(strap), .wp(wp), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, int act, int expv, string what);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] devb(logic [2:0] code, logic [2:0] st, bit hi, bit rd);
    return {code, st, hi, rd};
  endfunction

  function automatic logic [7:0] model_rd(logic [8:0] a);
    if (a == LATCH) return {7'b0, m_wel};
    if (a > MAXA) return 8'hFF;
    return exp_mem[a];
  endfunction

  function automatic logic [8:0] lin_next(logic [8:0] a);
    return (a == MAXA) ? 9'd0 : a + 9'd1;
  endfunction

  task automatic bus_start;
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(Q); m_scl = 1'b1; tick(2*Q); m_scl = 1'b0; tick(Q);
    end
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
    ack = (sda_line == 1'b0);
    tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit mack);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); m_scl = 1'b1; tick(Q); b[i] = sda_line; tick(Q); m_scl = 1'b0; tick(Q);
    end
    m_sda = !mack; tick(Q); m_scl = 1'b1; tick(2*Q); m_scl = 1'b0; tick(Q);
    m_sda = 1'b1;
  endtask

  task automatic mem_cmp(string req);
    int mism = 0;
    for (int i = 0; i < 512; i++) if (dut_mem[i] !== exp_mem[i]) mism++;
    check(req, mism, 0, "memory image mismatches");
  endtask

  task automatic wr(logic [8:0] a, logic [7:0] dq[$], string req);
    bit ack;
    bit wrote = 1'b0;
    bus_start;
    send_byte(devb(CODE, strap, a[8], 1'b0), ack);
    check("R2", ack, 1, "write header ack");
    if (!ack) begin bus_stop; return; end
    send_byte(a[7:0], ack);
    check("R3", ack, 1, "address byte ack");
    m_ptr = a;
    foreach (dq[i]) begin
      bit ok;
      ok = !wp && (m_ptr == LATCH || (m_wel && m_ptr <= MAXA));
      send_byte(dq[i], ack);
      check(req, ack, ok, "data ack");
      if (m_ptr == LATCH) begin
        if (!wp) m_wel = dq[i][0];
      end else if (ok) begin
        exp_mem[m_ptr] = dq[i];
        wrote = 1'b1;
      end
      m_ptr = {m_ptr[8:4], m_ptr[3:0] + 4'd1};
    end
    bus_stop;
    if (wrote) m_busy = 1'b1;
    tick(4);
    mem_cmp(req);
  endtask

  task automatic rd(bit random, logic [8:0] a, int n, string req);
    bit ack;
    logic [7:0] b;
    bus_start;
    if (random) begin
      send_byte(devb(CODE, strap, a[8], 1'b0), ack);
      check("R10", ack, 1, "random read write header ack");
      send_byte(a[7:0], ack);
      check("R10", ack, 1, "random read address ack");
      m_ptr = a;
      bus_start;
    end
    send_byte(devb(CODE, strap, 1'b0, 1'b1), ack);
    check("R10", ack, 1, "read header ack");
    for (int i = 0; i < n; i++) begin
      recv_byte(b, i != n - 1);
      check(req, b, model_rd(m_ptr), "read data");
      m_ptr = lin_next(m_ptr);
    end
    check("R11", sda_oe, 0, "data line released after master nack");
    bus_stop;
  endtask

  task automatic poll(bit exp_ack, string req);
    bit ack;
    bus_start;
    send_byte(devb(CODE, strap, 1'b0, 1'b0), ack);
    check(req, ack, exp_ack, "poll header ack");
    bus_stop;
  endtask

  task automatic wait_nv;
    tick(NV + 100);
    m_busy = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL R1 watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit ack;
    for (int i = 0; i < 512; i++) begin
      dut_mem[i] = 8'(i * 37 + 5);
      exp_mem[i] = 8'(i * 37 + 5);
    end
    tick(5);
    check("R1", sda_oe, 0, "sda_oe in reset");
    check("R1", mem_we, 0, "mem_we in reset");
    rst_n = 1'b1;
    tick(5);

    rd(1'b1, LATCH, 1, "R4");                        // enable bit reads 0
    wr(9'h010, '{8'hA5}, "R6");                      // refused, enable clear
    wr(LATCH, '{8'h01}, "R4");                       // set enable
    rd(1'b1, LATCH, 1, "R4");

    wr(9'h01E, '{8'h11, 8'h22, 8'h33, 8'h44}, "R8"); // page wrap, R7 strobes
    poll(1'b0, "R13");
    wait_nv;
    poll(1'b1, "R13");
    rd(1'b1, 9'h01E, 4, "R9");                       // linear across page
    rd(1'b1, 9'h010, 2, "R8");
    rd(1'b0, 9'h000, 2, "R9");                       // current-address read

    wr(9'h105, '{8'h5A}, "R3");
    wait_nv;
    rd(1'b1, 9'h105, 1, "R3");
    rd(1'b1, 9'h10F, 2, "R9");                       // wrap 10F -> 000

    wr(9'h120, '{8'h77}, "R12");
    rd(1'b1, 9'h1F0, 1, "R12");

    wp = 1'b1; tick(4);
    wr(LATCH, '{8'h00}, "R5");
    wr(9'h030, '{8'h99}, "R5");
    wp = 1'b0; tick(4);
    rd(1'b1, LATCH, 1, "R5");

    bus_start;
    send_byte(devb(CODE, strap ^ 3'b001, 1'b0, 1'b0), ack);
    check("R2", ack, 0, "wrong strap header ack");
    send_byte(8'h40, ack);
    check("R1", ack, 0, "byte after refused header");
    bus_stop;
    bus_start;
    send_byte(devb(3'b011, strap, 1'b0, 1'b0), ack);
    check("R2", ack, 0, "wrong code header ack");
    bus_stop;

    wr(LATCH, '{8'h01}, "R4");
    poll(1'b1, "R13");                               // latch-only write, no busy
    wr(9'h0F7, '{8'hC3, 8'h3C}, "R7");
    wait_nv;
    rd(1'b1, 9'h0F7, 2, "R7");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule